// File: doc/BRIEF.md
# Strided Row DMA Engine

The engine copies 32-bit words between a large word-addressed external memory and an 8 KB local scratch memory. The scratch memory is split into a lower and an upper 4 KB bank. Software loads a local address register and an external address register, then writes a packed transfer word. That write starts the copy. The `dir` input, sampled on the same write, picks the direction: external into local, or local out to external.

A transfer is two-dimensional. It is a number of rows of equal length. After each row the external pointer also jumps over a configurable gap. Row lengths are padded up to whole 8-byte units and clipped so that a row never runs past a 4 KB bank edge. Words that belong to the lower local bank are byte-reversed on the way through; upper-bank words are not.

Every word is moved with a plain request/acknowledge handshake on each memory port: one read from the source, then one write to the destination. The engine therefore works with any memory latency. Both address registers advance as rows complete, and they can be read on the outputs.

Top module: `strided_dma`

## Requirements
- R1: The transfer word is decoded as follows. Bits [11:0] plus one give the requested row length in bytes, which is then rounded up to a multiple of 8. Bits [19:12] plus one give the row count. Bits [31:20] give the external gap in bytes.
- R2: When a transfer starts, bits [2:0] of both address registers are cleared. An address register write in the same cycle as the start is taken into the start, and the clearing and clipping use the newly written value.
- R3: The row length is computed once, at the start. If (local address mod 4096) plus the rounded length exceeds 4096, the length becomes 4096 minus (local address mod 4096). That length is used for every row.
- R4: Word k of a row uses external byte address (ext_reg + 4k) AND 0x7FFFFC and local byte address (loc_reg + 4k) AND 0x1FFC. The local address therefore wraps within 8 KB, and every issued address is word aligned.
- R5: After each row, the local register grows by the row length and the external register grows by the row length plus the gap. Both are full 32-bit sums with no masking.
- R6: A word whose local address has bit 12 clear is byte-reversed (byte 0 swapped with byte 3, byte 1 swapped with byte 2) in both directions. A word whose local address has bit 12 set is copied unchanged.
- R7: With dir=0, each word is read from the external port and then written to the local port. With dir=1, each word is read from the local port and then written to the external port. The two ports are never requested in the same cycle.
- R8: A request, together with its address, write enable and write data, is held unchanged until the cycle in which its acknowledge is seen.
- R9: busy rises in the cycle after an accepted start. busy falls one cycle after the last word's write acknowledge. done is high for exactly one cycle, and that is the first cycle in which busy is low.
- R10: While busy, writes to the transfer word and to either address register are ignored.
- R11: After reset, busy, done and both requests are low, and both address registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_wr | input | 1 | Write strobe for the local address register |
| loc_in | input | 32 | Local address write value |
| ext_wr | input | 1 | Write strobe for the external address register |
| ext_in | input | 32 | External address write value |
| len_wr | input | 1 | Write strobe for the transfer word; starts a transfer |
| len_in | input | 32 | Packed length / count / gap word |
| dir | input | 1 | 0 = external to local, 1 = local to external |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| loc_addr_q | output | 32 | Local address register |
| ext_addr_q | output | 32 | External address register |
| ext_req | output | 1 | External memory request |
| ext_we | output | 1 | External write enable |
| ext_addr | output | 23 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data, valid with ext_ack |
| ext_ack | input | 1 | External acknowledge |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local write enable |
| loc_addr | output | 13 | Local byte address |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data, valid with loc_ack |
| loc_ack | input | 1 | Local acknowledge |

## Verification
Two events can coincide in one cycle: an address register write and the transfer start. The bench provokes this by writing the local address in the same cycle as the transfer word, while the register still holds the result of the previous run. The outcome is judged from the final register value and from the local addresses that were actually touched. Both must follow from the newly written address, not from the old one.

A second collision comes from writing all three registers in the middle of a transfer. The engine must finish the original transfer unchanged. This is judged by comparing both memories and both registers against an arithmetic model of the first transfer.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 8;
  localparam int GAP_W  = 12;
  localparam int WORD_W = LEN_W + CNT_W + GAP_W;
  localparam int ROW_W  = LEN_W + 1;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRC,
    ST_DST,
    ST_ROW
  } sdma_st_e;

  // Padded row length, clipped so the row stops at the 4 KB bank edge.
  function automatic logic [ROW_W-1:0] row_bytes(input logic [LEN_W-1:0] len_f,
                                                 input logic [LEN_W-1:0] loc_low);
    logic [ROW_W:0] want;
    logic [ROW_W:0] room;
    want = ({2'b00, len_f} + 14'd8) & ~14'd7;
    room = 14'h1000 - ({2'b00, loc_low} & ~14'd7);
    if (want > room) want = room;
    return want[ROW_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             start,
  input  logic             row_step,
  input  logic             loc_wr,
  input  logic [REG_W-1:0] loc_in,
  input  logic             ext_wr,
  input  logic [REG_W-1:0] ext_in,
  input  logic [ROW_W-1:0] row_len,
  input  logic [GAP_W-1:0] gap,
  output logic [LEN_W-1:0] loc_low,
  output logic [REG_W-1:0] loc_q,
  output logic [REG_W-1:0] ext_q
);
  localparam logic [REG_W-1:0] ALIGN8 = ~REG_W'(7);

  logic [REG_W-1:0] loc_eff;
  logic [REG_W-1:0] ext_eff;

  // A write in the start cycle feeds straight into the start.
  always_comb begin
    loc_eff = (loc_wr && !busy) ? loc_in : loc_q;
    ext_eff = (ext_wr && !busy) ? ext_in : ext_q;
    loc_low = loc_eff[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_q <= '0;
      ext_q <= '0;
    end else if (start) begin
      loc_q <= loc_eff & ALIGN8;
      ext_q <= ext_eff & ALIGN8;
    end else if (row_step) begin
      loc_q <= loc_q + REG_W'(row_len);
      ext_q <= ext_q + REG_W'(row_len) + REG_W'(gap);
    end else if (!busy) begin
      if (loc_wr) loc_q <= loc_in;
      if (ext_wr) ext_q <= ext_in;
    end
  end
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_wr,
  input  logic [WORD_W-1:0] len_in,
  input  logic              dir_in,
  input  logic [LEN_W-1:0]  loc_low,
  input  logic              src_ack,
  input  logic              dst_ack,
  output sdma_st_e          st,
  output logic [ROW_W-1:0]  offset,
  output logic [ROW_W-1:0]  row_len,
  output logic [GAP_W-1:0]  gap,
  output logic              dir_q,
  output logic              busy,
  output logic              done,
  output logic              start,
  output logic              row_step,
  output logic              word_done
);
  logic [CNT_W-1:0] rows_left;
  logic             last_word;

  always_comb begin
    busy      = (st != ST_IDLE);
    start     = (st == ST_IDLE) && len_wr;
    row_step  = (st == ST_ROW);
    word_done = (st == ST_DST) && dst_ack;
    last_word = ({1'b0, offset} + 14'd4) >= {1'b0, row_len};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      offset    <= '0;
      row_len   <= '0;
      gap       <= '0;
      rows_left <= '0;
      dir_q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (len_wr) begin
          row_len   <= row_bytes(len_in[LEN_W-1:0], loc_low);
          rows_left <= len_in[LEN_W +: CNT_W];
          gap       <= len_in[LEN_W+CNT_W +: GAP_W];
          dir_q     <= dir_in;
          offset    <= '0;
          st        <= ST_SRC;
        end
        ST_SRC: if (src_ack) st <= ST_DST;
        ST_DST: if (dst_ack) begin
          if (last_word) st <= ST_ROW;
          else begin
            offset <= offset + ROW_W'(4);
            st     <= ST_SRC;
          end
        end
        ST_ROW: begin
          offset <= '0;
          if (rows_left == '0) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            rows_left <= rows_left - 1'b1;
            st        <= ST_SRC;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strided_dma.sv
module strided_dma
  import sdma_pkg::*;
#(
  parameter int EXT_AW = 23,
  parameter int LOC_AW = 13,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_wr,
  input  logic [REG_W-1:0]  loc_in,
  input  logic              ext_wr,
  input  logic [REG_W-1:0]  ext_in,
  input  logic              len_wr,
  input  logic [WORD_W-1:0] len_in,
  input  logic              dir,
  output logic              busy,
  output logic              done,
  output logic [REG_W-1:0]  loc_addr_q,
  output logic [REG_W-1:0]  ext_addr_q,
  output logic              ext_req,
  output logic              ext_we,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ack,
  output logic              loc_req,
  output logic              loc_we,
  output logic [LOC_AW-1:0] loc_addr,
  output logic [DATA_W-1:0] loc_wdata,
  input  logic [DATA_W-1:0] loc_rdata,
  input  logic              loc_ack
);
  localparam int BANK_BIT = LOC_AW - 1;

  sdma_st_e          st;
  logic [ROW_W-1:0]  offset;
  logic [ROW_W-1:0]  row_len;
  logic [GAP_W-1:0]  gap;
  logic              dir_q;
  logic              start;
  logic              row_step;
  logic              word_done;
  logic [LEN_W-1:0]  loc_low;
  logic              src_phase;
  logic              dst_phase;
  logic              src_ack;
  logic              dst_ack;
  logic [DATA_W-1:0] src_rdata;
  logic [DATA_W-1:0] data_q;
  logic [EXT_AW-1:0] ext_sum;
  logic [LOC_AW-1:0] loc_sum;
  logic              loc_lower;

  sdma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_wr   (len_wr),
    .len_in   (len_in),
    .dir_in   (dir),
    .loc_low  (loc_low),
    .src_ack  (src_ack),
    .dst_ack  (dst_ack),
    .st       (st),
    .offset   (offset),
    .row_len  (row_len),
    .gap      (gap),
    .dir_q    (dir_q),
    .busy     (busy),
    .done     (done),
    .start    (start),
    .row_step (row_step),
    .word_done(word_done)
  );

  sdma_regs #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .start   (start),
    .row_step(row_step),
    .loc_wr  (loc_wr),
    .loc_in  (loc_in),
    .ext_wr  (ext_wr),
    .ext_in  (ext_in),
    .row_len (row_len),
    .gap     (gap),
    .loc_low (loc_low),
    .loc_q   (loc_addr_q),
    .ext_q   (ext_addr_q)
  );

  always_comb begin
    src_phase = (st == ST_SRC);
    dst_phase = (st == ST_DST);
    ext_sum   = ext_addr_q[EXT_AW-1:0] + EXT_AW'(offset);
    loc_sum   = loc_addr_q[LOC_AW-1:0] + LOC_AW'(offset);
    ext_addr  = ext_sum & ~EXT_AW'(3);
    loc_addr  = loc_sum & ~LOC_AW'(3);
    loc_lower = !loc_addr[BANK_BIT];
    ext_req   = dir_q ? dst_phase : src_phase;
    loc_req   = dir_q ? src_phase : dst_phase;
    ext_we    = dir_q;
    loc_we    = !dir_q;
    src_ack   = dir_q ? loc_ack : ext_ack;
    dst_ack   = dir_q ? ext_ack : loc_ack;
    src_rdata = dir_q ? loc_rdata : ext_rdata;
    ext_wdata = data_q;
    loc_wdata = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else if (src_phase && src_ack)
      data_q <= loc_lower ? swap_bytes(src_rdata) : src_rdata;
  end
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
  parameter int EXT_AW = 23,
  parameter int LOC_AW = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              len_wr,
  input logic              row_step,
  input logic              word_done,
  input logic              ext_req,
  input logic              ext_ack,
  input logic [EXT_AW-1:0] ext_addr,
  input logic [31:0]       ext_wdata,
  input logic              loc_req,
  input logic              loc_ack,
  input logic [LOC_AW-1:0] loc_addr,
  input logic [31:0]       loc_wdata
);
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) !(ext_req && loc_req)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!ext_req && !loc_req)); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && len_wr) |=> busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_DONE_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(row_step)); // R5
  AST_ROW_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n) $rose(row_step) |-> $past(word_done)); // R7
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_wdata))); // R8
  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_wdata))); // R8
  AST_EXT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) ext_req |-> (ext_addr[1:0] == 2'b00)); // R4
  AST_LOC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) loc_req |-> (loc_addr[1:0] == 2'b00)); // R4
endmodule

bind strided_dma sdma_chk #(.EXT_AW(EXT_AW), .LOC_AW(LOC_AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .len_wr   (len_wr),
  .row_step (row_step),
  .word_done(word_done),
  .ext_req  (ext_req),
  .ext_ack  (ext_ack),
  .ext_addr (ext_addr),
  .ext_wdata(ext_wdata),
  .loc_req  (loc_req),
  .loc_ack  (loc_ack),
  .loc_addr (loc_addr),
  .loc_wdata(loc_wdata)
);

// File: tb/strided_dma_tb_top.sv
`timescale 1ns/1ps
module strided_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_wr = 1'b0, ext_wr = 1'b0, len_wr = 1'b0, dir_in = 1'b0;
  logic [31:0] loc_in = '0, ext_in = '0, len_in = '0;
  logic        busy, done;
  logic [31:0] loc_addr_q, ext_addr_q;
  logic        ext_req, ext_we, loc_req, loc_we;
  logic [22:0] ext_addr;
  logic [12:0] loc_addr;
  logic [31:0] ext_wdata, loc_wdata;
  logic [31:0] ext_rdata = '0, loc_rdata = '0;
  logic        ext_ack = 1'b0, loc_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int hs_bad = 0;
  int excl_bad = 0;
  int run_id = 0;

  logic [31:0] loc_mem [0:2047];
  logic [31:0] exp_loc [0:2047];
  logic [31:0] ext_mem [int unsigned];
  logic [31:0] exp_ext [int unsigned];

  always #2.5 clk = ~clk;

  strided_dma dut_i (
    .clk(clk), .rst_n(rst_n),
    .loc_wr(loc_wr), .loc_in(loc_in), .ext_wr(ext_wr), .ext_in(ext_in),
    .len_wr(len_wr), .len_in(len_in), .dir(dir_in),
    .busy(busy), .done(done), .loc_addr_q(loc_addr_q), .ext_addr_q(ext_addr_q),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_ack(ext_ack),
    .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_ack(loc_ack)
  );

  function automatic logic [31:0] ext_init(input int unsigned w);
    return (w * 32'h0100_0193) ^ 32'h5BD1_E995;
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] d);
    return ((d >> 24) & 32'hFF) | ((d >> 8) & 32'hFF00) | ((d << 8) & 32'hFF_0000) | (d << 24);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory models: acknowledge after 0..2 cycles, sampled away from the clock edge.
  int ext_cnt = 0, loc_cnt = 0, lat_e = 0, lat_l = 1;
  logic [22:0] ext_a0;
  logic [12:0] loc_a0;
  always @(negedge clk) begin
    if (ext_req && loc_req) excl_bad++;
    if (ext_ack) begin
      ext_ack = 1'b0; ext_cnt = 0;
    end else if (ext_req) begin
      if (ext_cnt == 0) ext_a0 = ext_addr;
      else if (ext_addr !== ext_a0) hs_bad++;
      if (ext_cnt >= lat_e) begin
        if (ext_we) ext_mem[ext_addr >> 2] = ext_wdata;
        else ext_rdata = ext_mem.exists(ext_addr >> 2) ? ext_mem[ext_addr >> 2] : ext_init(ext_addr >> 2);
        ext_ack = 1'b1;
        lat_e = (lat_e + 1) % 3;
      end
      ext_cnt++;
    end
    if (loc_ack) begin
      loc_ack = 1'b0; loc_cnt = 0;
    end else if (loc_req) begin
      if (loc_cnt == 0) loc_a0 = loc_addr;
      else if (loc_addr !== loc_a0) hs_bad++;
      if (loc_cnt >= lat_l) begin
        if (loc_we) loc_mem[loc_addr[12:2]] = loc_wdata;
        else loc_rdata = loc_mem[loc_addr[12:2]];
        loc_ack = 1'b1;
        lat_l = (lat_l + 2) % 3;
      end
      loc_cnt++;
    end
  end

  // Arithmetic model of a transfer, written from the requirements.
  task automatic ref_model(input bit dir, input logic [31:0] loc0, ext0, lenw,
                           output logic [31:0] fl, output logic [31:0] fe);
    int unsigned n, low, la, ea;
    logic [31:0] loc, ext, w;
    n   = lenw[11:0] + 1;
    n   = ((n + 7) / 8) * 8;
    loc = loc0 & 32'hFFFF_FFF8;
    ext = ext0 & 32'hFFFF_FFF8;
    low = loc % 4096;
    if (low + n > 4096) n = 4096 - low;
    for (int r = 0; r <= int'(lenw[19:12]); r++) begin
      for (int unsigned b = 0; b < n; b += 4) begin
        la = (loc + b) & 32'h1FFC;
        ea = (ext + b) & 32'h7F_FFFC;
        if (!dir) begin
          w = ext_init(ea >> 2);
          exp_loc[la >> 2] = (la < 4096) ? bsw(w) : w;
        end else begin
          w = exp_loc[la >> 2];
          exp_ext[ea >> 2] = (la < 4096) ? bsw(w) : w;
        end
      end
      loc = loc + n;
      ext = ext + n + {20'd0, lenw[31:20]};
    end
    fl = loc;
    fe = ext;
  endtask

  task automatic do_run(input bit dir, input logic [31:0] loc0, ext0, lenw,
                        input bit same, input bit disturb);
    logic [31:0] fl, fe;
    int n, mism;
    logic [31:0] first_a, first_v;
    run_id++;
    for (int i = 0; i < 2048; i++) loc_mem[i] = i * 32'h9E37_79B9 + run_id;
    ext_mem.delete();
    exp_ext.delete();
    exp_loc = loc_mem;
    ref_model(dir, loc0, ext0, lenw, fl, fe);
    hs_bad = 0;
    excl_bad = 0;
    @(negedge clk);
    ext_wr = 1'b1; ext_in = ext0;
    if (!same) begin loc_wr = 1'b1; loc_in = loc0; end
    @(negedge clk);
    ext_wr = 1'b0; loc_wr = 1'b0;
    if (same) begin loc_wr = 1'b1; loc_in = loc0; end   // R2: write in the start cycle
    len_wr = 1'b1; len_in = lenw; dir_in = dir;
    @(negedge clk);
    loc_wr = 1'b0; len_wr = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
    if (disturb) begin
      @(negedge clk);
      len_wr = 1'b1; len_in = 32'h0000_0FFF; dir_in = ~dir;   // R10: ignored
      loc_wr = 1'b1; loc_in = 32'h0000_0100;
      ext_wr = 1'b1; ext_in = 32'h0000_4444;
      @(negedge clk);
      len_wr = 1'b0; loc_wr = 1'b0; ext_wr = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1 && busy === 1'b0, "R9 done with busy low", {30'd0, done, busy}, 32'd2);
    chk(loc_addr_q === fl, "R1 R2 R3 R5 R10 local register", loc_addr_q, fl);
    chk(ext_addr_q === fe, "R1 R2 R5 R10 external register", ext_addr_q, fe);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", {31'd0, done}, 32'd0);
    mism = 0; first_a = 0; first_v = 0;
    for (int i = 0; i < 2048; i++)
      if (loc_mem[i] !== exp_loc[i]) begin
        if (mism == 0) begin first_a = i; first_v = loc_mem[i]; end
        mism++;
      end
    chk(mism == 0, "R1 R3 R4 R6 R7 local memory", first_v, exp_loc[first_a[10:0]]);
    mism = 0;
    foreach (exp_ext[k])
      if (!ext_mem.exists(k) || ext_mem[k] !== exp_ext[k]) mism++;
    chk(mism == 0 && ext_mem.num() == exp_ext.num(), "R1 R4 R6 R7 external memory",
        ext_mem.num(), exp_ext.num());
    chk(hs_bad == 0, "R8 request held until acknowledge", hs_bad, 0);
    chk(excl_bad == 0, "R7 one port at a time", excl_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] lens [4] = '{12'd0, 12'd7, 12'd8, 12'd100};
    logic [31:0] locs [3] = '{32'h0000_0005, 32'h0000_0FF3, 32'h0000_1FE8};
    logic [31:0] exts [2] = '{32'h0000_0123, 32'h007F_FFF9};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R11 reset flags", {30'd0, busy, done}, 0);
    chk(ext_req === 1'b0 && loc_req === 1'b0, "R11 reset requests", {30'd0, ext_req, loc_req}, 0);
    chk(loc_addr_q === 0 && ext_addr_q === 0, "R11 reset registers", loc_addr_q | ext_addr_q, 0);
    for (int d = 0; d < 2; d++)
      for (int li = 0; li < 4; li++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 3; a++)
            for (int e = 0; e < 2; e++)
              do_run(d[0], locs[a], exts[e],
                     {(li[0] ? 12'h024 : 12'h000), (c == 0 ? 8'd0 : 8'd2), lens[li]},
                     a[0] ^ e[0], 1'b0);
    // R3: full bank row from bank start, both directions
    do_run(1'b0, 32'h0000_1000, 32'h0000_0040, 32'h0000_0FFF, 1'b0, 1'b0);
    do_run(1'b1, 32'h0000_0000, 32'h0000_2000, 32'h0000_0FFF, 1'b1, 1'b0);
    // R10: register and start writes during a transfer
    do_run(1'b0, 32'h0000_0204, 32'h0000_0300, 32'h0081_2030, 1'b0, 1'b1);
    do_run(1'b1, 32'h0000_1404, 32'h0001_0000, 32'h0101_1050, 1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule